// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one character per request into a frame on a single asynchronous serial line. The frame format comes from a six-bit control word that is presented with the request. The word carries three packed fields: a character-size code, a parity code and a stop-bit selector. Data widths of five to nine bits, even, odd or no parity, and one or two stop bits are all chosen per frame, and reserved codes map to fixed, documented formats.

Bit timing comes entirely from an external baud-tick enable: every bit on the line lasts exactly one tick period. A start strobe seen while the block is idle captures the data and the control word. The next tick begins the start bit, and each later tick moves the line to the next bit. The tick that closes the last stop bit returns the block to idle and raises a one-cycle completion pulse. Baud-rate division, buffering and receive are handled elsewhere.

Top module: `txf_top`

## Requirements
- R1: After reset the line is high, busy is low and done is low; the line is high whenever busy is low. An all-zero control word gives 5 data bits, no parity and 1 stop bit.
- R2: A frame is one low start bit, then the data bits least significant first, then the parity bit when enabled, then the stop bits (high). Each bit lasts exactly one baud-tick period, and the line changes only on a clock edge where the tick is high.
- R3: The size field is ctrl[2:0]: code 000 sends 5 data bits, 001 sends 6, 010 sends 7, 011 sends 8 and 111 sends 9 (data[8:0]).
- R4: The reserved size codes 100, 101 and 110 send 8 data bits.
- R5: The parity field is ctrl[4:3]: code 10 appends even parity and 11 appends odd parity, both computed over only the data bits actually sent.
- R6: Parity codes 00 and 01 send no parity bit.
- R7: The stop field is ctrl[5]: 0 sends one stop bit and 1 sends two.
- R8: Data and control word are captured on the accepted start strobe; changing them later has no effect on the frame in flight.
- R9: Busy rises on the clock edge that accepts a start strobe while idle and stays high until the last stop bit ends; a start strobe while busy is ignored.
- R10: Done is high for exactly one clock cycle, on the edge where the final stop bit completes, and busy falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable marking each bit boundary |
| ctrl | input | 6 | Frame format: [2:0] size, [4:3] parity, [5] stop |
| data | input | 9 | Character, least significant bit sent first |
| start | input | 1 | Request to send one frame |
| line_out | output | 1 | Serial line, idles high |
| busy | output | 1 | Frame accepted and not yet finished |
| done | output | 1 | One-cycle pulse at end of the last stop bit |

## Verification
The assertions check the cycle-level rules on every clock: the line rests high whenever the block is idle, it moves only on tick edges, busy can rise only after a start strobe, and done is a single cycle coinciding with busy falling after a tick. The actual bit sequence, which depends on the size, parity and stop decode, the reserved-code mapping, the parity value and the capture of inputs at the strobe, is only visible through the bench's scenarios, which compare every bit period against an independently built expected frame and scramble the inputs and re-strobe during each frame.

// File: rtl/txf_pkg.sv
package txf_pkg;
  // Control word field positions
  localparam int SIZE_LSB = 0;
  localparam int PAR_LSB  = 3;
  localparam int STOP_BIT = 5;
  localparam int CTRL_W   = 6;

  typedef struct packed {
    logic [3:0] nbits;     // data bits in frame
    logic       par_en;    // parity bit appended
    logic       par_odd;   // odd rather than even parity
    logic       two_stop;  // two stop bits
  } frame_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_t;
endpackage

// File: rtl/txf_fmt_decode.sv
module txf_fmt_decode
  import txf_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl,
  output frame_cfg_t        cfg
);
  logic [2:0] size_code;
  logic [1:0] par_code;

  assign size_code = ctrl[SIZE_LSB +: 3];
  assign par_code  = ctrl[PAR_LSB +: 2];

  always_comb begin
    unique case (size_code)
      3'b000:  cfg.nbits = 4'd5;
      3'b001:  cfg.nbits = 4'd6;
      3'b010:  cfg.nbits = 4'd7;
      3'b011:  cfg.nbits = 4'd8;
      3'b111:  cfg.nbits = 4'd9;
      default: cfg.nbits = 4'd8;   // reserved sizes fall back to 8
    endcase
    cfg.par_en   = par_code[1];    // 01 reserved behaves as disabled
    cfg.par_odd  = par_code[0];
    cfg.two_stop = ctrl[STOP_BIT];
  end
endmodule

// File: rtl/txf_frame_build.sv
module txf_frame_build
  import txf_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = 1 + DATA_W + 1 + 2,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  frame_cfg_t        cfg,
  input  logic [DATA_W-1:0] data,
  output logic [FRAME_W-1:0] frame,
  output logic [CNT_W-1:0]   len
);
  logic par_bit;
  int   nb;
  int   total;

  always_comb begin
    nb      = int'(cfg.nbits);
    par_bit = cfg.par_odd;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) par_bit = par_bit ^ data[i];
    end
    frame    = '1;          // stop bits and padding are high
    frame[0] = 1'b0;        // start bit
    for (int i = 0; i < DATA_W; i++) begin
      if (i < nb) frame[1 + i] = data[i];
    end
    for (int j = 0; j < FRAME_W; j++) begin
      if (cfg.par_en && (j == 1 + nb)) frame[j] = par_bit;
    end
    total = 1 + nb + (cfg.par_en ? 1 : 0) + (cfg.two_stop ? 2 : 1);
    len   = CNT_W'(total);
  end
endmodule

// File: rtl/txf_top.sv
module txf_top
  import txf_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              baud_tick,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] data,
  input  logic              start,
  output logic              line_out,
  output logic              busy,
  output logic              done
);
  localparam int FRAME_W = 1 + DATA_W + 1 + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  frame_cfg_t          cfg;
  logic [FRAME_W-1:0]  frame_new;
  logic [CNT_W-1:0]    len_new;

  tx_state_t           state_q;
  logic [FRAME_W-1:0]  frame_q;
  logic [CNT_W-1:0]    left_q;
  logic                line_q;
  logic                busy_q;
  logic                done_q;

  txf_fmt_decode u_decode (
    .ctrl (ctrl),
    .cfg  (cfg)
  );

  txf_frame_build #(
    .DATA_W  (DATA_W),
    .FRAME_W (FRAME_W),
    .CNT_W   (CNT_W)
  ) u_build (
    .cfg   (cfg),
    .data  (data),
    .frame (frame_new),
    .len   (len_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      frame_q <= '1;
      left_q  <= '0;
      line_q  <= 1'b1;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            frame_q <= frame_new;
            left_q  <= len_new;
            busy_q  <= 1'b1;
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (baud_tick) begin
            line_q  <= frame_q[0];
            frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
            left_q  <= left_q - 1'b1;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (baud_tick) begin
            if (left_q == '0) begin
              line_q  <= 1'b1;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              line_q  <= frame_q[0];
              frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
              left_q  <= left_q - 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign line_out = line_q;
  assign busy     = busy_q;
  assign done     = done_q;

  // Idle line rests high
  assert_idle_line_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line_out);

  // Line moves only on tick edges
  assert_tick_paced_R2: assert property (@(posedge clk) disable iff (rst)
    !baud_tick |=> $stable(line_out));

  // Busy only rises after a strobe
  assert_busy_entry_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  // Done lasts a single cycle
  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // Done coincides with busy falling on a tick
  assert_done_end_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy) && $past(baud_tick)));
endmodule

// File: tb/tb_txf_top.sv
module tb_txf_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick = 1'b0;
  logic [5:0] ctrl = 6'd0;
  logic [8:0] data = 9'd0;
  logic       start = 1'b0;
  logic       line_out, busy, done;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_q[$];
  string cur_tag = "R1";
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  txf_top dut (
    .clk (clk), .rst (rst), .baud_tick (baud_tick), .ctrl (ctrl),
    .data (data), .start (start), .line_out (line_out), .busy (busy),
    .done (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Expected frame from the requirements
  task automatic push_frame(input logic [5:0] c, input logic [8:0] d);
    int n;
    bit p;
    case (c[2:0])
      3'b000: n = 5;
      3'b001: n = 6;
      3'b010: n = 7;
      3'b111: n = 9;
      default: n = 8;
    endcase
    exp_q.push_back(1'b0);
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(d[i]);
      p ^= d[i];
    end
    if (c[4:3] == 2'b10) exp_q.push_back(p);
    if (c[4:3] == 2'b11) exp_q.push_back(~p);
    exp_q.push_back(1'b1);
    if (c[5]) exp_q.push_back(1'b1);
  endtask

  // Tick generator and monitor in one process at the falling edge
  bit was_tick = 0, was_busy = 0, want_done_low = 0;
  int tdiv = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (want_done_low) begin
        chk(done == 1'b0, "R10 done width", done, 0);
        want_done_low = 0;
      end
      if (was_tick && was_busy) begin
        if (busy) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, {"R2/", cur_tag, " extra bit"}, line_out, 1);
          end else begin
            bit e;
            e = exp_q.pop_front();
            chk(line_out == e, {"R2/", cur_tag}, line_out, e);
          end
        end else begin
          chk(done == 1'b1, "R10 done at end", done, 1);
          chk(exp_q.size() == 0, {"R2/", cur_tag, " frame length"}, exp_q.size(), 0);
          chk(line_out == 1'b1, "R1 idle after frame", line_out, 1);
          exp_q.delete();
          want_done_low = 1;
        end
      end
    end
    was_busy = busy;
    tdiv = (tdiv == 3) ? 0 : tdiv + 1;
    baud_tick = (tdiv == 3);
    was_tick = baud_tick;
  end

  task automatic send(input logic [5:0] c, input logic [8:0] d,
                      input string tag, input bit restrobe);
    while (busy) @(negedge clk);
    cur_tag = tag;
    push_frame(c, d);
    ctrl  = c;
    data  = d;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    // R8: scramble inputs while the frame is in flight
    ctrl = ~c;
    data = ~d;
    if (restrobe) begin
      repeat (9) @(negedge clk);
      // R9: this strobe must be ignored
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(line_out == 1'b1, "R1 reset line", line_out, 1);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    send(6'b0_00_000, 9'h0B5, "R1", 0);          // all-zero word: 5N1
    send(6'b0_00_001, 9'h12D, "R3", 0);
    send(6'b0_00_010, 9'h055, "R3", 1);
    send(6'b0_00_011, 9'h0C3, "R3", 0);
    send(6'b0_00_111, 9'h1A6, "R3", 1);
    send(6'b0_00_100, 9'h1FF, "R4", 0);
    send(6'b0_10_101, 9'h0F1, "R4", 0);
    send(6'b0_11_110, 9'h080, "R4", 1);
    send(6'b0_10_000, 9'h007, "R5", 0);          // parity over 5 bits only
    send(6'b0_11_000, 9'h1E7, "R5", 0);
    send(6'b0_10_111, 9'h1FF, "R5", 0);
    send(6'b0_11_111, 9'h100, "R5", 1);
    send(6'b0_11_011, 9'h000, "R5", 0);
    send(6'b0_01_011, 9'h0A5, "R6", 0);
    send(6'b0_01_111, 9'h133, "R6", 1);
    send(6'b1_00_000, 9'h011, "R7", 0);
    send(6'b1_11_111, 9'h0AA, "R7", 1);
    send(6'b1_10_010, 9'h05C, "R8", 1);
    finished = 1;
  end

  initial begin
    while (!finished && cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    if (!finished) chk(1'b0, "watchdog", cycles, 150000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule